// File: doc/BRIEF.md
# Bus Request to RAM Access Bridge

The bridge takes requests from a valid/ready request port and turns them into accesses on a single-ported synchronous RAM. Each request carries an address, a data word, a per-byte enable mask and a two-bit operation code. A write request becomes a RAM write in the cycle it is accepted.

A read request does not produce a read response. The bridge reads one RAM word and sends it out as a new write on a second valid/ready port. That write goes to the address held in the low bits of the read request's data field, and it always has every byte enabled.

Only one read is handled at a time. The request port stays blocked from the moment a read is accepted until its outgoing write has been taken. Operation codes that are neither read nor write are accepted and dropped, and an error pulse is raised.

Top module: `bus_ram_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` and `bad_op` are 0 and `req_ready` is 1.
- R2: When a request with code 0 (write) is accepted, `ram_en` and `ram_we` are 1 in that same cycle. `ram_addr`, `ram_wdata` and `ram_be` equal the request's address, data and byte mask unchanged. The RAM updates only the bytes whose mask bit is set (bit b covers data bits 8b+7..8b).
- R3: When a request with code 1 (read) is accepted, `ram_en` is 1 and `ram_we` is 0 in that cycle. `ram_addr` and `ram_be` equal the request's fields.
- R4: Two clock edges after a read is accepted, `out_valid` is 1. `out_data` holds the RAM word that was read. `out_addr` holds the low address-width bits of the read request's data field.
- R5: Whenever `out_valid` is 1, `out_be` has every bit set and `out_op` is 0 (write).
- R6: A request with code 2 or 3 is accepted. It causes no RAM access and leaves memory contents unchanged. `bad_op` is 1 for exactly the cycle after the acceptance.
- R7: `req_ready` is 0 from the edge that accepts a read until the edge where the outgoing write completes its handshake. It is 1 again from the following cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_data` hold their values.
- R9: Write requests presented on consecutive cycles are accepted one per cycle, with no idle cycle between them.
- R10: Asserting reset in the middle of a read drops the outgoing write. `out_valid` is 0 and `req_ready` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can take a request |
| req_op | input | 2 | 0 write, 1 read, 2 and 3 illegal |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Write data, or the return address for a read |
| req_be | input | DATA_W/8 | Byte enable mask |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | 1 for a write, 0 for a read |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_be | output | DATA_W/8 | RAM byte enables |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after a read strobe |
| out_valid | output | 1 | Outgoing write present |
| out_ready | input | 1 | Outgoing write taken |
| out_op | output | 2 | Always 0 (write) |
| out_addr | output | ADDR_W | Return address taken from the read request's data |
| out_data | output | DATA_W | Word fetched from RAM |
| out_be | output | DATA_W/8 | All ones |
| bad_op | output | 1 | One-cycle pulse after an illegal code is accepted |

## Verification
The bench builds the bridge with a 4-bit address and a 16-bit data word, so the RAM model has sixteen words and the byte mask has two bits. With that size the bench can write every address back to back and apply every mask value, including the empty mask, across the array. It then reads every word back with a different return address and a stall length that cycles through 0 to 2. Both illegal codes are sent, and a read is cut off by reset while its outgoing write is waiting.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_READ  = 2'd1,
        OP_RSV_A = 2'd2,
        OP_RSV_B = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        KIND_WRITE,
        KIND_READ,
        KIND_BAD
    } req_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND
    } seq_state_e;

    function automatic req_kind_e classify(input logic [1:0] op);
        case (op)
            OP_WRITE: classify = KIND_WRITE;
            OP_READ:  classify = KIND_READ;
            default:  classify = KIND_BAD;
        endcase
    endfunction

endpackage

// File: rtl/br_decode.sv
module br_decode
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              take,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [BE_W-1:0]   be,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [BE_W-1:0]   ram_be,
    output logic              take_read,
    output logic              take_bad
);
    req_kind_e kind;

    always_comb begin
        kind      = classify(op);
        ram_en    = take && (kind != KIND_BAD);
        ram_we    = (kind == KIND_WRITE);
        ram_addr  = addr;
        ram_wdata = data;
        ram_be    = be;
        take_read = take && (kind == KIND_READ);
        take_bad  = take && (kind == KIND_BAD);
    end
endmodule

// File: rtl/br_sequencer.sv
module br_sequencer
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take_read,
    input  logic take_bad,
    input  logic out_ready,
    output logic req_ready,
    output logic cap_data,
    output logic out_valid,
    output logic bad_op
);
    seq_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bad_op  <= 1'b0;
        end else begin
            bad_op <= take_bad;
            case (state_q)
                ST_IDLE:  if (take_read) state_q <= ST_FETCH;
                ST_FETCH: state_q <= ST_SEND;
                ST_SEND:  if (out_ready) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cap_data  = (state_q == ST_FETCH);
        out_valid = (state_q == ST_SEND);
    end
endmodule

// File: rtl/br_return_buf.sv
module br_return_buf #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cap_data,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    logic [ADDR_W-1:0] ret_addr;

    generate
        if (DATA_W >= ADDR_W) begin : g_slice
            assign ret_addr = req_data[ADDR_W-1:0];
        end else begin : g_extend
            assign ret_addr = {{(ADDR_W-DATA_W){1'b0}}, req_data};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_addr <= '0;
            out_data <= '0;
        end else begin
            if (cap_addr) out_addr <= ret_addr;
            if (cap_data) out_data <= ram_rdata;
        end
    end
endmodule

// File: rtl/bus_ram_bridge.sv
module bus_ram_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [BE_W-1:0]   req_be,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [BE_W-1:0]   ram_be,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_op,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [BE_W-1:0]   out_be,
    output logic              bad_op
);
    generate
        if (DATA_W % 8 != 0) begin : g_width_check
            $error("DATA_W must be a whole number of bytes");
        end
    endgenerate

    logic take;
    logic take_read;
    logic take_bad;
    logic cap_data;

    assign take   = req_valid && req_ready;
    assign out_op = OP_WRITE;
    assign out_be = '1;

    br_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .take      (take),
        .op        (req_op),
        .addr      (req_addr),
        .data      (req_data),
        .be        (req_be),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_be    (ram_be),
        .take_read (take_read),
        .take_bad  (take_bad)
    );

    br_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .take_read (take_read),
        .take_bad  (take_bad),
        .out_ready (out_ready),
        .req_ready (req_ready),
        .cap_data  (cap_data),
        .out_valid (out_valid),
        .bad_op    (bad_op)
    );

    br_return_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ret (
        .clk       (clk),
        .rst       (rst),
        .cap_addr  (take_read),
        .req_data  (req_data),
        .cap_data  (cap_data),
        .ram_rdata (ram_rdata),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );
endmodule

// File: rtl/bridge_checks.sv
module bridge_checks #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic              ram_en,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_op,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic [BE_W-1:0]   out_be,
    input logic              bad_op
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_reset_clean_r1: assert property (@(posedge clk) $past(rst) |-> (!out_valid && !bad_op && req_ready))
        else $error("reset state wrong");

    p_ram_on_legal_accept_r2: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> (acc && !req_op[1]))
        else $error("RAM strobe without legal accepted request");

    p_out_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 2'd1) |=> ##1 out_valid)
        else $error("outgoing write late");

    p_out_fields_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_be == {BE_W{1'b1}} && out_op == 2'd0))
        else $error("outgoing write fields wrong");

    p_bad_follows_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op[1]) |=> bad_op)
        else $error("bad_op missing");

    p_bad_cause_r6: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> $past(acc && req_op[1]))
        else $error("bad_op without cause");

    p_block_after_read_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 2'd1) |=> !req_ready)
        else $error("request port open during read");

    p_block_while_out_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready)
        else $error("request port open while sending");

    p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)))
        else $error("outgoing write changed while stalled");
endmodule

bind bus_ram_bridge bridge_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .ram_en    (ram_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_op    (out_op),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .out_be    (out_be),
    .bad_op    (bad_op)
);

// File: tb/bus_ram_bridge_test.sv
`timescale 1ns/1ps
module bus_ram_bridge_test;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int BW = DW / 8;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [BW-1:0] req_be = '0;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [BW-1:0] ram_be;
    logic [DW-1:0] ram_rdata;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [1:0]    out_op;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;
    logic [BW-1:0] out_be;
    logic          bad_op;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] expv [WORDS];

    always #2 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    always_ff @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                for (int b = 0; b < BW; b++)
                    if (ram_be[b]) mem[ram_addr][b*8 +: 8] <= ram_wdata[b*8 +: 8];
            end else begin
                ram_rdata <= mem[ram_addr];
            end
        end
    end

    bus_ram_bridge #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [BW-1:0] be);
        logic [DW-1:0] r = old;
        for (int b = 0; b < BW; b++)
            if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [BW-1:0] be);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_be = be;
        #0.5;
        while (!req_ready) begin @(negedge clk); #0.5; end
        if (op == 2'd0)
            chk("R2", {ram_en, ram_we, ram_addr, ram_wdata, ram_be}, {1'b1, 1'b1, a, d, be});
        else if (op == 2'd1)
            chk("R3", {ram_en, ram_we, ram_addr, ram_be}, {1'b1, 1'b0, a, be});
        else
            chk("R6", ram_en, 1'b0);
        @(negedge clk);
        if (op == 2'd0) expv[a] = merge(expv[a], d, be);
    endtask

    task automatic read_back(input logic [AW-1:0] a, input logic [AW-1:0] ret, input int stall);
        issue(2'd1, a, {{(DW-AW){1'b1}}, ret}, 2'b01);
        req_valid = 1'b0;
        #0.5;
        chk("R7", {req_ready, out_valid}, 2'b00);
        @(negedge clk);
        chk("R4", {out_valid, out_addr, out_data}, {1'b1, ret, expv[a]});
        chk("R5", {out_be, out_op}, {{BW{1'b1}}, 2'd0});
        chk("R7", req_ready, 1'b0);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R8", {out_valid, out_addr, out_data}, {1'b1, ret, expv[a]});
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        #0.5;
        chk("R7", {out_valid, req_ready}, 2'b01);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int t0;
        for (int i = 0; i < WORDS; i++) begin mem[i] = '0; expv[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1", {out_valid, bad_op, req_ready}, 3'b001);
        rst = 1'b0;
        #0.5;
        chk("R1", {out_valid, bad_op, req_ready, ram_en}, 4'b0010);
        @(negedge clk);

        // Back-to-back full-word writes to every address.
        t0 = cycles;
        for (int a = 0; a < WORDS; a++)
            issue(2'd0, a[AW-1:0], DW'(a * 16'h1111 ^ 16'h5A3C), '1);
        chk("R9", cycles - t0, WORDS);
        req_valid = 1'b0;
        @(negedge clk);

        // Every mask value, including the empty one.
        for (int a = 0; a < WORDS; a++)
            issue(2'd0, a[AW-1:0], DW'(16'hC000 + a * 16'h0123), BW'(a));
        req_valid = 1'b0;

        // Illegal codes: no access, pulse for one cycle.
        for (int k = 2; k < 4; k++) begin
            issue(k[1:0], 4'd3, 16'hFFFF, '1);
            req_valid = 1'b0;
            #0.5;
            chk("R6", bad_op, 1'b1);
            @(negedge clk);
            chk("R6", bad_op, 1'b0);
        end

        // Read every word back, with varied return addresses and stalls.
        for (int a = 0; a < WORDS; a++)
            read_back(a[AW-1:0], AW'(WORDS - 1 - a), a % 3);

        // Reset cuts a pending outgoing write.
        issue(2'd1, 4'd5, 16'h0009, '1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10", out_valid, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        chk("R10", {out_valid, req_ready}, 2'b01);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", {out_valid, req_ready}, 2'b01);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule